// File: doc/BRIEF.md
# Look-up-table sine oscillator for a digital phase-locked loop

This block is the numerically controlled oscillator that closes an all-digital phase-locked loop. Each enabled sample, a 32-bit phase register is advanced by a tuning word. The tuning word is the sum of a fixed centre step and a scaled signed correction taken from the loop filter. The default centre step sets about 1 MHz at a 100 MHz sample rate. The upper ten bits of the phase address a sine table, and the table value is registered as the oscillator output.

The phase register is the unit delay of the loop. A change on the correction input has no combinational path to the sine output, so the loop filter can be placed directly ahead of this block. The stored table covers only a quarter of the wave. The other three quarters are obtained by mirroring the offset within the quadrant and negating the value in the second half-cycle. Output words are signed 16-bit two's complement with 14 fraction bits. The peak amplitude is 0.99, so the result always stays clear of the format limits.

Top module: `nco_lut_osc`

## Requirements
- R1: A synchronous active-high reset clears both the phase register and the sine output to zero. The first enabled sample after reset therefore outputs 0.
- R2: On every clock edge with the sample enable high, the phase register adds the tuning word and wraps modulo 2^32.
- R3: The tuning word is 42949673 plus the 16-bit control word, sign-extended to 32 bits and shifted left by 8 places (two's complement, modulo 2^32).
- R4: While the sample enable is low, the phase register and the sine output both hold, whatever the control word does.
- R5: The sine output equals round(0.99 · 2^14 · sin(2π·A/1024)), rounded half away from zero, where A is bits 31..22 of the phase register before the enabled edge. The output register updates on that same edge, one sample behind the phase.
- R6: The magnitude of the sine output never exceeds 16220, which is round(0.99 · 2^14).
- R7: Table addresses 0 to 511 give values of 0 or more, and addresses 512 to 1023 give values of 0 or less. An address in the second half returns the negation of the value at the address 512 below it.
- R8: The control word is applied on the same enabled edge at which it is presented. It can change on every sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Advances the oscillator by one sample when high |
| ctrl_word | input | 16 | Signed correction from the loop filter |
| sine_out | output | 16 | Signed sine sample with 14 fraction bits |

## Verification
The assertions check on every cycle the cleared state after reset, the per-sample phase step against the control input, the hold when the enable is low, the amplitude bound, and the sign rule for each half-cycle. Only the bench's runs can show that the sine values themselves are right. It compares each enabled sample against a model that computes the sine directly with real arithmetic. The model tracks the phase across wraps, across control words that are steady, extreme or change every sample, and across gaps in the enable.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Magnitude of one quarter-wave entry: round(amp * 2^frac * sin(pi/2 * k / 2^qbits)).
  function automatic int quarter_sample(int k, int qbits, int frac_w, int permille);
    real ang;
    real mag;
    ang = 1.5707963267948966 * real'(k) / real'(1 << qbits);
    mag = (real'(permille) / 1000.0) * real'(1 << frac_w) * $sin(ang);
    return $rtoi(mag + 0.5);
  endfunction

  // Largest code the table can hold (value at a quarter turn).
  function automatic int peak_code(int frac_w, int permille);
    real mag;
    mag = (real'(permille) / 1000.0) * real'(1 << frac_w);
    return $rtoi(mag + 0.5);
  endfunction

endpackage

// File: rtl/nco_tune.sv
module nco_tune #(
  parameter int ACC_W      = 32,
  parameter int CTRL_W     = 16,
  parameter int CTRL_SHIFT = 8,
  parameter logic [ACC_W-1:0] BASE_INC = 42949673
) (
  input  logic signed [CTRL_W-1:0] ctrl,
  output logic        [ACC_W-1:0]  tw
);
  logic signed [ACC_W-1:0] ctrl_wide;
  logic signed [ACC_W-1:0] ctrl_scaled;

  assign ctrl_wide   = ACC_W'(ctrl);
  assign ctrl_scaled = ctrl_wide <<< CTRL_SHIFT;
  assign tw          = BASE_INC + ctrl_scaled;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] tw,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (en) begin
      phase <= phase + tw;
    end
  end

  // R2: each enabled sample moves the phase by exactly the tuning word (modulo 2^ACC_W)
  p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> (phase == ACC_W'($past(phase) + $past(tw))));
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 16,
  parameter int FRAC_W       = 14,
  parameter int AMP_PERMILLE = 990
) (
  input  logic        [ADDR_W-1:0] addr,
  output logic signed [DATA_W-1:0] sample
);
  import nco_pkg::*;

  localparam int QB   = ADDR_W - 2;
  localparam int QLEN = (1 << QB) + 1;
  localparam logic [QB:0] QTOP = (QB + 1)'(1) << QB;

  logic [DATA_W-1:0] qtab [QLEN];

  for (genvar k = 0; k < QLEN; k++) begin : g_qtab
    localparam int V = quarter_sample(k, QB, FRAC_W, AMP_PERMILLE);
    assign qtab[k] = DATA_W'(V);
  end

  logic [1:0]        quad;
  logic [QB-1:0]     off;
  logic [QB:0]       sel;
  logic [DATA_W-1:0] mag;

  assign quad   = addr[ADDR_W-1 -: 2];
  assign off    = addr[QB-1:0];
  assign sel    = quad[0] ? (QTOP - {1'b0, off}) : {1'b0, off};
  assign mag    = qtab[sel];
  assign sample = quad[1] ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/nco_lut_osc.sv
module nco_lut_osc #(
  parameter int ACC_W        = 32,
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 16,
  parameter int FRAC_W       = 14,
  parameter int CTRL_W       = 16,
  parameter int CTRL_SHIFT   = 8,
  parameter int AMP_PERMILLE = 990,
  parameter logic [ACC_W-1:0] BASE_INC = 42949673
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_en,
  input  logic signed [CTRL_W-1:0] ctrl_word,
  output logic signed [DATA_W-1:0] sine_out
);
  import nco_pkg::*;

  localparam int PEAK = peak_code(FRAC_W, AMP_PERMILLE);
  localparam logic signed [DATA_W-1:0] PEAK_POS = DATA_W'(PEAK);
  localparam logic signed [DATA_W-1:0] PEAK_NEG = DATA_W'(-PEAK);

  logic [ACC_W-1:0]         tw;
  logic [ACC_W-1:0]         phase;
  logic [ADDR_W-1:0]        rom_addr;
  logic signed [DATA_W-1:0] rom_sample;

  nco_tune #(
    .ACC_W(ACC_W), .CTRL_W(CTRL_W), .CTRL_SHIFT(CTRL_SHIFT), .BASE_INC(BASE_INC)
  ) i_tune (
    .ctrl(ctrl_word),
    .tw  (tw)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) i_acc (
    .clk  (clk),
    .rst  (rst),
    .en   (sample_en),
    .tw   (tw),
    .phase(phase)
  );

  assign rom_addr = phase[ACC_W-1 -: ADDR_W];

  nco_quarter_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .AMP_PERMILLE(AMP_PERMILLE)
  ) i_rom (
    .addr  (rom_addr),
    .sample(rom_sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sine_out <= '0;
    end else if (sample_en) begin
      sine_out <= rom_sample;
    end
  end

  // Independent view of the requested step, for the port-level check of R3 and R8
  logic [ACC_W-1:0] ctrl_step_chk;
  assign ctrl_step_chk = ACC_W'(ctrl_word) << CTRL_SHIFT;

  // R1: the first cycle after reset shows a cleared phase and output
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase == '0 && sine_out == '0));

  // R3, R8: the step taken follows the control word presented at that edge
  p_step_from_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (ACC_W'(phase - $past(phase)) == ACC_W'(BASE_INC + $past(ctrl_step_chk))));

  // R4: nothing moves without the enable
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(phase) && $stable(sine_out)));

  // R6: output stays within the scaled amplitude
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (sine_out <= PEAK_POS) && (sine_out >= PEAK_NEG));

  // R7: second half-cycle is never positive, first half-cycle never negative
  p_neg_half_r7: assert property (@(posedge clk) disable iff (rst)
    (sample_en && rom_addr[ADDR_W-1]) |=> (sine_out <= 0));
  p_pos_half_r7: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !rom_addr[ADDR_W-1]) |=> (sine_out >= 0));
endmodule

// File: tb/test_nco_lut_osc.sv
`timescale 1ns/1ps
module test_nco_lut_osc;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sample_en = 1'b0;
  logic signed [15:0] ctrl_word = '0;
  logic signed [15:0] sine_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  longint model_acc = 0;
  int wraps = 0;

  always #5 clk = ~clk;

  nco_lut_osc i_nco_lut_osc (
    .clk(clk), .rst(rst), .sample_en(sample_en),
    .ctrl_word(ctrl_word), .sine_out(sine_out)
  );

  function automatic int ref_sine(int a);
    real x;
    x = 0.99 * 16384.0 * $sin(2.0 * 3.141592653589793 * real'(a) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic longint tune_of(int c);
    return 64'd42949673 + longint'(c) * 256;
  endfunction

  task automatic check_val(string req, int got, int exp, int tol);
    int d;
    checks++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // One enabled sample from a negedge; compares at the following negedge.
  task automatic sample(int c, string req);
    int exp, a;
    sample_en = 1'b1;
    ctrl_word = 16'(c);
    a = int'(model_acc >> 22) & 1023;
    exp = ref_sine(a);
    @(posedge clk);
    model_acc = model_acc + tune_of(c);
    if (model_acc >= 64'h1_0000_0000) wraps++;
    model_acc = model_acc & 64'hFFFF_FFFF;
    @(negedge clk);
    check_val(req, int'(sine_out), exp, 1);
    // R6 bound and R7 sign per sample
    checks++;
    if (int'(sine_out) > 16220 || int'(sine_out) < -16220) begin
      fails++;
      $display("FAIL R6: got %0d expected magnitude <= 16220", int'(sine_out));
    end
    checks++;
    if ((a >= 512 && int'(sine_out) > 0) || (a < 512 && int'(sine_out) < 0)) begin
      fails++;
      $display("FAIL R7: got %0d expected sign for address %0d", int'(sine_out), a);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sample_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_acc = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int held;
    @(negedge clk);
    do_reset();
    check_val("R1 reset output", int'(sine_out), 0, 0);
    sample(0, "R1 first sample");
    // Steady centre frequency, several full turns (R2 wrap, R5 values)
    for (int i = 0; i < 3000; i++) sample(0, "R5 centre");
    checks++;
    if (wraps < 5) begin
      fails++;
      $display("FAIL R2: got %0d wraps expected at least 5", wraps);
    end
    // Extreme and mid corrections (R3)
    for (int i = 0; i < 1500; i++) sample(32767, "R3 max ctrl");
    for (int i = 0; i < 1500; i++) sample(-32768, "R3 min ctrl");
    for (int i = 0; i < 1000; i++) sample(1234, "R3 small ctrl");
    for (int i = 0; i < 1000; i++) sample(-5000, "R3 negative ctrl");
    // Control word changing every sample (R8)
    for (int i = 0; i < 2000; i++) sample(((i * 7919) % 65536) - 32768, "R8 per-sample ctrl");
    // Enable low holds phase and output (R4)
    held = int'(sine_out);
    for (int i = 0; i < 12; i++) begin
      sample_en = 1'b0;
      ctrl_word = 16'(i * 3001 - 20000);
      @(negedge clk);
      check_val("R4 hold output", int'(sine_out), held, 0);
    end
    for (int i = 0; i < 200; i++) sample(300, "R4 phase held across gap");
    // Sparse enable: one sample every third clock
    for (int i = 0; i < 400; i++) begin
      sample(-700, "R4 sparse enable");
      sample_en = 1'b0;
      repeat (2) @(negedge clk);
    end
    // Reset in mid-run (R1)
    do_reset();
    check_val("R1 mid-run reset output", int'(sine_out), 0, 0);
    sample(32767, "R1 first sample after reset");
    for (int i = 0; i < 500; i++) sample(-1, "R5 after reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule